// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the receive and transmit status flags of a serial port that runs in asynchronous or synchronous mode. The receiver core reports each finished character with a strobe, the character, its parity bit and its multiprocessor bit. The transmitter core reports when it has taken the pending byte and when the final bit of a character is leaving the line. From these events the block keeps a parity error flag, a transmit end flag, a multiprocessor bit, a receive-data-full flag and a transmit-data-empty flag. It also holds the receive data register.

Software reads all flags through one 8-bit status view. A flag that software may clear only drops after software has first read it as 1 and then writes 0 to its bit. A pending parity error stalls the receiver. In synchronous mode it also holds off the transmitter. When the receiver is disabled, the receive-side flags keep their values.

Top module: `ser_status_flags`

## Requirements
- R1: After reset the parity error flag, the multiprocessor bit and the receive-data-full flag are 0, transmit end and transmit-data-empty are 1, the receive data register is 0, and both hold outputs are 0.
- R2: The status view `rdData` carries transmit-data-empty at bit 7, receive-data-full at bit 6, parity error at bit 3, transmit end at bit 2 and the multiprocessor bit at bit 1. All other bits read 0.
- R3: A character is accepted when `rxDone` is 1, `rxEn` is 1 and no parity error is pending. If `parEnable` is 1, an accepted character sets the parity error flag when the XOR of all data bits and `rxParBit` differs from `parOdd` (0 selects even parity, 1 selects odd parity).
- R4: An accepted character with a parity error is still loaded into the receive data register, but it leaves receive-data-full unchanged.
- R5: An accepted character without a parity error is loaded into the receive data register and sets receive-data-full.
- R6: While the parity error flag is 1, `rxDone` is ignored: the data register and the flags are not changed. `rxHold` equals the parity error flag. `txHold` is 1 exactly when `syncMode` is 1 and the parity error flag is 1.
- R7: While `rxEn` is 0, receive strobes are ignored and the parity error flag and the multiprocessor bit keep their values. A software clear of the parity error flag still works.
- R8: Transmit-data-empty (bit 7), receive-data-full (bit 6) and parity error (bit 3) clear only when software writes 0 to the bit after reading that bit as 1 with `rdEn`. Writing 0 without such a read, or writing 1, has no effect.
- R9: Any write cancels every pending read-as-1 condition. A read, then a write with the bit at 1, then a write of 0 leaves the flag set.
- R10: Transmit end is set in every cycle where `txEn` is 0. It is also set when `txLastBit` arrives while transmit-data-empty is 1. It is not set by `txLastBit` while transmit-data-empty is 0.
- R11: Transmit end is read-only and clears together with a valid clear of transmit-data-empty. `txTake` sets transmit-data-empty.
- R12: The multiprocessor bit is read-only. It takes `rxMpBit` from each accepted character while `mpFormat` is 1, and it is unchanged by characters received while `mpFormat` is 0.
- R13: When a hardware set event and a software clear hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rdEn | input | 1 | CPU read strobe of the status register |
| wrEn | input | 1 | CPU write strobe of the status register |
| wrData | input | 8 | CPU write data |
| rdData | output | 8 | Status register view |
| rxEn | input | 1 | Receiver enable |
| txEn | input | 1 | Transmitter enable |
| syncMode | input | 1 | 1 selects synchronous mode |
| parEnable | input | 1 | Parity checking enable |
| parOdd | input | 1 | 0 selects even parity, 1 selects odd parity |
| mpFormat | input | 1 | Multiprocessor character format |
| rxDone | input | 1 | Receiver finished a character |
| rxWord | input | DW | Received character |
| rxParBit | input | 1 | Received parity bit |
| rxMpBit | input | 1 | Received multiprocessor bit |
| txTake | input | 1 | Transmitter moved the pending byte into its shifter |
| txLastBit | input | 1 | Last bit of a character is being shifted out |
| rxDataOut | output | DW | Receive data register |
| rxHold | output | 1 | Reception stalled by a pending error |
| txHold | output | 1 | Synchronous transmission stalled by a pending error |

## Verification
The in-module assertions watch, on every cycle, the properties that can be stated at a single step. A pending error blocks acceptance. A disabled receiver leaves the error flag frozen, and a disabled transmitter forces transmit end. An errored character raises the error flag without raising data-full. A good character wins over a same-cycle clear. Captured multiprocessor bits match their input. Only the bench scenarios can show the behaviours that span several transactions. These are the read-then-write clear handshake, the cancelling of an arm by an intervening write, the read-only nature of transmit end and the multiprocessor bit, and the exact values loaded into the data register under even and odd parity.

// File: rtl/ser_status_pkg.sv
package ser_status_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned BIT_TXE  = 7;
  localparam int unsigned BIT_RXF  = 6;
  localparam int unsigned BIT_PER  = 3;
  localparam int unsigned BIT_TEND = 2;
  localparam int unsigned BIT_MPB  = 1;

  typedef struct packed {
    logic clrTxEmpty;
    logic clrRxFull;
    logic clrParErr;
    logic rxAccept;
    logic rxParFail;
    logic loadMp;
  } ctlStrobes_t;
endpackage

// File: rtl/ser_status_ctrl.sv
module ser_status_ctrl
  import ser_status_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             rxEn,
  input  logic             parEnable,
  input  logic             parOdd,
  input  logic             mpFormat,
  input  logic             rxDone,
  input  logic [DW-1:0]    rxWord,
  input  logic             rxParBit,
  input  logic             txEmpty,
  input  logic             rxFull,
  input  logic             parErr,
  output ctlStrobes_t      strb
);
  localparam int unsigned NCLR = 3;

  logic [NCLR-1:0] flagNow;
  logic [NCLR-1:0] armed;
  logic [NCLR-1:0] wrBit;
  logic [NCLR-1:0] clrHit;

  assign flagNow = {txEmpty, rxFull, parErr};
  assign wrBit   = {wrData[BIT_TXE], wrData[BIT_RXF], wrData[BIT_PER]};

  genvar g;
  generate
    for (g = 0; g < NCLR; g++) begin : gArm
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                    armed[g] <= 1'b0;
        else if (wrEn)                armed[g] <= 1'b0;
        else if (rdEn && flagNow[g])  armed[g] <= 1'b1;
      end
      assign clrHit[g] = wrEn && !wrBit[g] && armed[g];
    end
  endgenerate

  logic accept;
  logic parMismatch;

  assign accept      = rxDone && rxEn && !parErr;
  assign parMismatch = (^{rxWord, rxParBit}) != parOdd;

  always_comb begin
    strb            = '0;
    strb.clrTxEmpty = clrHit[2];
    strb.clrRxFull  = clrHit[1];
    strb.clrParErr  = clrHit[0];
    strb.rxAccept   = accept;
    strb.rxParFail  = accept && parEnable && parMismatch;
    strb.loadMp     = accept && mpFormat;
  end

  AST_ARM_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armed[1]) |-> $past(rdEn && rxFull && !wrEn)); // R8
  AST_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (armed == '0)); // R9
endmodule

// File: rtl/ser_status_datapath.sv
module ser_status_datapath
  import ser_status_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobes_t   strb,
  input  logic          rxEn,
  input  logic          txEn,
  input  logic          txTake,
  input  logic          txLastBit,
  input  logic [DW-1:0] rxWord,
  input  logic          rxMpBit,
  output logic          txEmpty,
  output logic          txEnd,
  output logic          rxFull,
  output logic          parErr,
  output logic          mpBit,
  output logic [DW-1:0] rxData
);
  logic txEndSet;
  logic rxFullSet;
  logic parErrSet;

  assign txEndSet  = !txEn || (txLastBit && txEmpty);
  assign rxFullSet = strb.rxAccept && !strb.rxParFail;
  assign parErrSet = strb.rxAccept && strb.rxParFail;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEmpty <= 1'b1;
      txEnd   <= 1'b1;
      rxFull  <= 1'b0;
      parErr  <= 1'b0;
      mpBit   <= 1'b0;
      rxData  <= '0;
    end else begin
      if (txTake)               txEmpty <= 1'b1;
      else if (strb.clrTxEmpty) txEmpty <= 1'b0;

      if (txEndSet)             txEnd <= 1'b1;
      else if (strb.clrTxEmpty) txEnd <= 1'b0;

      if (rxFullSet)            rxFull <= 1'b1;
      else if (strb.clrRxFull)  rxFull <= 1'b0;

      if (parErrSet)            parErr <= 1'b1;
      else if (strb.clrParErr)  parErr <= 1'b0;

      if (strb.loadMp)          mpBit <= rxMpBit;
      if (strb.rxAccept)        rxData <= rxWord;
    end
  end

  AST_STALL_ON_ERR: assert property (@(posedge clk) disable iff (!rstN)
    parErr |-> !strb.rxAccept); // R6
  AST_ERR_NO_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rxAccept && strb.rxParFail && !rxFull) |=> (parErr && !rxFull)); // R4
  AST_RX_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEn && !strb.clrParErr) |=> ($stable(parErr) && $stable(mpBit))); // R7
  AST_TXEND_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |=> txEnd); // R10
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rxAccept && !strb.rxParFail && strb.clrRxFull) |=> rxFull); // R13
  AST_MP_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadMp |=> (mpBit == $past(rxMpBit))); // R12
endmodule

// File: rtl/ser_status_flags.sv
module ser_status_flags
  import ser_status_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             rxEn,
  input  logic             txEn,
  input  logic             syncMode,
  input  logic             parEnable,
  input  logic             parOdd,
  input  logic             mpFormat,
  input  logic             rxDone,
  input  logic [DW-1:0]    rxWord,
  input  logic             rxParBit,
  input  logic             rxMpBit,
  input  logic             txTake,
  input  logic             txLastBit,
  output logic [DW-1:0]    rxDataOut,
  output logic             rxHold,
  output logic             txHold
);
  ctlStrobes_t strb;
  logic txEmpty, txEnd, rxFull, parErr, mpBit;

  ser_status_ctrl #(.DW(DW)) uCtrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .rxEn(rxEn), .parEnable(parEnable), .parOdd(parOdd), .mpFormat(mpFormat),
    .rxDone(rxDone), .rxWord(rxWord), .rxParBit(rxParBit),
    .txEmpty(txEmpty), .rxFull(rxFull), .parErr(parErr), .strb(strb)
  );

  ser_status_datapath #(.DW(DW)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .rxEn(rxEn), .txEn(txEn),
    .txTake(txTake), .txLastBit(txLastBit), .rxWord(rxWord), .rxMpBit(rxMpBit),
    .txEmpty(txEmpty), .txEnd(txEnd), .rxFull(rxFull), .parErr(parErr),
    .mpBit(mpBit), .rxData(rxDataOut)
  );

  always_comb begin
    rdData           = '0;
    rdData[BIT_TXE]  = txEmpty;
    rdData[BIT_RXF]  = rxFull;
    rdData[BIT_PER]  = parErr;
    rdData[BIT_TEND] = txEnd;
    rdData[BIT_MPB]  = mpBit;
  end

  assign rxHold = parErr;
  assign txHold = syncMode && parErr;
endmodule

// File: tb/ser_status_flags_test.sv
module ser_status_flags_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rdEn = 0, wrEn = 0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       rxEn = 0, txEn = 0, syncMode = 0, parEnable = 0, parOdd = 0, mpFormat = 0;
  logic       rxDone = 0, rxParBit = 0, rxMpBit = 0, txTake = 0, txLastBit = 0;
  logic [7:0] rxWord = '0;
  logic [7:0] rxDataOut;
  logic       rxHold, txHold;
  int         checks = 0;
  int         errors = 0;

  always #10 clk = ~clk;

  ser_status_flags uut (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .rxEn(rxEn), .txEn(txEn), .syncMode(syncMode), .parEnable(parEnable), .parOdd(parOdd),
    .mpFormat(mpFormat), .rxDone(rxDone), .rxWord(rxWord), .rxParBit(rxParBit),
    .rxMpBit(rxMpBit), .txTake(txTake), .txLastBit(txLastBit),
    .rxDataOut(rxDataOut), .rxHold(rxHold), .txHold(txHold)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rdReg();
    @(negedge clk); rdEn = 1;
    @(negedge clk); rdEn = 0;
  endtask

  task automatic wrReg(input logic [7:0] v);
    @(negedge clk); wrEn = 1; wrData = v;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rxChar(input logic [7:0] d, input logic p, input logic m);
    @(negedge clk); rxDone = 1; rxWord = d; rxParBit = p; rxMpBit = m;
    @(negedge clk); rxDone = 0;
  endtask

  task automatic pulseTx(input logic take, input logic last);
    @(negedge clk); txTake = take; txLastBit = last;
    @(negedge clk); txTake = 0; txLastBit = 0;
  endtask

  task automatic tReset();
    chk("R1", "status", {24'd0, rdData}, 32'h84);
    chk("R1", "data", {24'd0, rxDataOut}, 32'h0);
    chk("R1", "holds", {30'd0, rxHold, txHold}, 32'h0);
  endtask

  task automatic tGoodRx();
    rxChar(8'h03, 1'b0, 1'b0);
    chk("R5", "status", {24'd0, rdData}, 32'hC4);
    chk("R5", "data", {24'd0, rxDataOut}, 32'h03);
  endtask

  task automatic tClearHandshake();
    wrReg(8'h00);
    chk("R8", "no read clear", {24'd0, rdData}, 32'hC4);
    rdReg(); wrReg(8'hFF); wrReg(8'h00);
    chk("R9", "disarmed", {24'd0, rdData}, 32'hC4);
    rdReg(); wrReg(8'hBF);
    chk("R8", "rxFull cleared", {24'd0, rdData}, 32'h84);
  endtask

  task automatic tParityErr();
    rxChar(8'h01, 1'b0, 1'b0);
    chk("R3", "status", {24'd0, rdData}, 32'h8C);
    chk("R4", "data loaded", {24'd0, rxDataOut}, 32'h01);
    chk("R6", "rxHold", {31'd0, rxHold}, 32'h1);
    rxChar(8'hAA, 1'b0, 1'b0);
    chk("R6", "stalled data", {24'd0, rxDataOut}, 32'h01);
    chk("R6", "stalled status", {24'd0, rdData}, 32'h8C);
    @(negedge clk); syncMode = 1;
    @(negedge clk);
    chk("R6", "txHold sync", {31'd0, txHold}, 32'h1);
    syncMode = 0;
    @(negedge clk);
    chk("R6", "txHold async", {31'd0, txHold}, 32'h0);
  endtask

  task automatic tFreeze();
    @(negedge clk); rxEn = 0;
    @(negedge clk);
    chk("R7", "err kept", {24'd0, rdData}, 32'h8C);
    rdReg(); wrReg(8'hF7);
    chk("R7", "err cleared", {24'd0, rdData}, 32'h84);
    rxChar(8'h01, 1'b0, 1'b0);
    chk("R7", "bad ignored", {24'd0, rdData}, 32'h84);
    chk("R7", "data kept", {24'd0, rxDataOut}, 32'h01);
    @(negedge clk); mpFormat = 1;
    rxChar(8'h10, 1'b0, 1'b1);
    chk("R7", "mp kept", {24'd0, rdData}, 32'h84);
    @(negedge clk); mpFormat = 0; rxEn = 1;
  endtask

  task automatic tOdd();
    @(negedge clk); parOdd = 1;
    rxChar(8'h07, 1'b0, 1'b0);
    chk("R3", "odd ok", {24'd0, rdData}, 32'hC4);
    chk("R5", "odd data", {24'd0, rxDataOut}, 32'h07);
    rdReg(); wrReg(8'hBF);
  endtask

  task automatic tMp();
    @(negedge clk); parEnable = 0; mpFormat = 1;
    rxChar(8'h10, 1'b1, 1'b1);
    chk("R12", "mp set", {24'd0, rdData}, 32'hC6);
    rdReg(); wrReg(8'hFD);
    chk("R12", "mp readonly", {24'd0, rdData}, 32'hC6);
    rxChar(8'h20, 1'b0, 1'b0);
    chk("R12", "mp zero", {24'd0, rdData}, 32'hC4);
    @(negedge clk); mpFormat = 0;
    rxChar(8'h30, 1'b0, 1'b1);
    chk("R12", "normal fmt", {24'd0, rdData}, 32'hC4);
    chk("R5", "data 30", {24'd0, rxDataOut}, 32'h30);
    rdReg(); wrReg(8'hBF);
    chk("R2", "layout", {24'd0, rdData}, 32'h84);
  endtask

  task automatic tTxEnd();
    rdReg(); wrReg(8'h7F);
    chk("R11", "both clear", {24'd0, rdData}, 32'h00);
    pulseTx(1'b0, 1'b1);
    chk("R10", "no set when full", {24'd0, rdData}, 32'h00);
    pulseTx(1'b1, 1'b0);
    chk("R11", "take sets empty", {24'd0, rdData}, 32'h80);
    pulseTx(1'b0, 1'b1);
    chk("R10", "last bit sets", {24'd0, rdData}, 32'h84);
    rdReg(); wrReg(8'hFB);
    chk("R11", "tend readonly", {24'd0, rdData}, 32'h84);
    rdReg(); wrReg(8'h7F);
    @(negedge clk); txEn = 0;
    @(negedge clk);
    chk("R10", "tx disabled", {24'd0, rdData}, 32'h04);
    txEn = 1;
  endtask

  task automatic tPriority();
    pulseTx(1'b1, 1'b0);
    rxChar(8'h41, 1'b0, 1'b0);
    chk("R13", "pre", {24'd0, rdData}, 32'hC4);
    rdReg();
    @(negedge clk);
    wrEn = 1; wrData = 8'h3F; rxDone = 1; rxWord = 8'h42; txTake = 1;
    @(negedge clk);
    wrEn = 0; rxDone = 0; txTake = 0;
    chk("R13", "set wins", {24'd0, rdData}, 32'hC0);
    chk("R13", "data", {24'd0, rxDataOut}, 32'h42);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1;
    @(negedge clk);
    tReset();
    txEn = 1; rxEn = 1; parEnable = 1; parOdd = 0;
    tGoodRx();
    tClearHandshake();
    tParityErr();
    tFreeze();
    tOdd();
    tMp();
    tTxEnd();
    tPriority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule